// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Control Generator

This block is the control path for a single-cycle processor that runs a reduced 32-bit load/store instruction set of 22 instructions. It is purely combinational. It reads the 6-bit major opcode and the 6-bit function field of the instruction currently in flight. It drives three groups of outputs: one identity line for each supported instruction, three class lines that group related instructions, and the control signals for the datapath.

The datapath uses these outputs in the same cycle. They steer the register-file write, the ALU second operand, the adder direction, the data memory strobes, the next-PC multiplexer and the destination-register multiplexer. An encoding outside the supported set raises an illegal flag. It also forces every write strobe low and leaves the PC on its sequential path, so a stray word cannot change architectural state. Branch instructions are identified but leave the next-PC select at its sequential value, because the taken path is resolved by the branch-condition logic in the datapath. The parameter `SPLIT_DECODE` selects how matching is built: either direct comparators for each instruction, or two full one-hot field decoders whose lines are ANDed.

Top module: `insn_decode_ctrl`

## Requirements
- R1: With opcode 0, the function field selects the instruction: 32 add, 34 sub, 42 slt, 36 and, 37 or, 38 xor, 39 nor, 8 jr, 12 syscall.
- R2: Other opcodes select the instruction regardless of the function field: 15 lui, 8 addi, 10 slti, 12 andi, 13 ori, 14 xori, 35 lw, 43 sw, 2 j, 3 jal, 1 bltz, 4 beq, 5 bne.
- R3: `inst_o` has bit positions 0 through 21 assigned in this order: add, sub, slt, and, or, xor, nor, jr, syscall, lui, addi, slti, andi, ori, xori, lw, sw, j, jal, bltz, beq, bne. A recognised encoding sets exactly one bit and clears `illegal_o`. Any other encoding leaves every bit clear and sets `illegal_o`.
- R4: `arith_o` is high for add, sub, slt, addi and slti. `logic_o` is high for and, or, xor, nor, andi, ori and xori. `imm_o` is high for lui, addi, slti, andi, ori and xori.
- R5: `reg_wr_o` is high exactly for lui, lw, jal, and the arithmetic and logic classes.
- R6: `alu_imm_o` is high exactly for the immediate class, lw and sw.
- R7: `alu_sub_o` is high exactly for sub, slt and slti.
- R8: `mem_rd_o` is high only for lw, and `mem_wr_o` is high only for sw.
- R9: `pc_sel_o` bit 0 is high for j, jal and syscall, and bit 1 is high for jr and syscall. This gives 0 for sequential or branch, 1 for the jump target, 2 for the register target and 3 for the system-call entry.
- R10: `dst_sel_o` is 1 (rd field) for register-writing instructions with opcode 0, 2 (link register 31) for jal, and 0 (rt field) otherwise.
- R11: An unrecognised encoding drives `reg_wr_o`, `mem_rd_o`, `mem_wr_o` and `pc_sel_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Major opcode field |
| fn_i | input | 6 | Function field (used only when opcode is 0) |
| inst_o | output | 22 | One-hot instruction identity |
| arith_o | output | 1 | Arithmetic class |
| logic_o | output | 1 | Logic class |
| imm_o | output | 1 | Immediate-operand ALU class |
| reg_wr_o | output | 1 | Register file write enable |
| alu_imm_o | output | 1 | ALU second operand from immediate |
| alu_sub_o | output | 1 | Adder subtracts |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| pc_sel_o | output | 2 | Next-PC source select |
| dst_sel_o | output | 2 | Destination register select |
| illegal_o | output | 1 | Encoding not recognised |

## Verification
Every supported encoding is applied with a function value chosen so that it does not collide with another instruction. Each output group is compared against values derived from the class lists. Function-field values that overlap opcode values (8 and 12) are used on both sides: jr against addi, and syscall against andi. This shows that the two decode paths do not leak into each other. I-format opcodes are also applied with R-format function values, which shows that the function field is ignored outside opcode 0. Finally, an exhaustive sweep of all 4096 opcode and function pairs counts the illegal, register-write and memory-write responses, and these counts expose any extra or missing matches.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

   localparam int NUM_INST = 22;
   localparam int LAST_RFMT = 8;

   typedef enum logic [4:0] {
      IX_ADD, IX_SUB, IX_SLT, IX_AND, IX_OR, IX_XOR, IX_NOR, IX_JR, IX_SYSCALL,
      IX_LUI, IX_ADDI, IX_SLTI, IX_ANDI, IX_ORI, IX_XORI, IX_LW, IX_SW,
      IX_J, IX_JAL, IX_BLTZ, IX_BEQ, IX_BNE
   } insn_idx_e;

   localparam logic [1:0] PC_SEQ  = 2'd0;
   localparam logic [1:0] PC_JTA  = 2'd1;
   localparam logic [1:0] PC_REG  = 2'd2;
   localparam logic [1:0] PC_TRAP = 2'd3;

   localparam logic [1:0] DST_RT   = 2'd0;
   localparam logic [1:0] DST_RD   = 2'd1;
   localparam logic [1:0] DST_LINK = 2'd2;

   function automatic logic [5:0] op_code(input int idx);
      case (idx)
         IX_LUI:  op_code = 6'd15;
         IX_ADDI: op_code = 6'd8;
         IX_SLTI: op_code = 6'd10;
         IX_ANDI: op_code = 6'd12;
         IX_ORI:  op_code = 6'd13;
         IX_XORI: op_code = 6'd14;
         IX_LW:   op_code = 6'd35;
         IX_SW:   op_code = 6'd43;
         IX_J:    op_code = 6'd2;
         IX_JAL:  op_code = 6'd3;
         IX_BLTZ: op_code = 6'd1;
         IX_BEQ:  op_code = 6'd4;
         IX_BNE:  op_code = 6'd5;
         default: op_code = 6'd0;
      endcase
   endfunction

   function automatic logic [5:0] fn_code(input int idx);
      case (idx)
         IX_ADD:     fn_code = 6'd32;
         IX_SUB:     fn_code = 6'd34;
         IX_SLT:     fn_code = 6'd42;
         IX_AND:     fn_code = 6'd36;
         IX_OR:      fn_code = 6'd37;
         IX_XOR:     fn_code = 6'd38;
         IX_NOR:     fn_code = 6'd39;
         IX_JR:      fn_code = 6'd8;
         IX_SYSCALL: fn_code = 6'd12;
         default:    fn_code = 6'd0;
      endcase
   endfunction

   function automatic bit is_rfmt(input int idx);
      return idx <= LAST_RFMT;
   endfunction

endpackage

// File: rtl/insn_match.sv
module insn_match
   import insn_dec_pkg::*;
#(
   parameter int  OP_W         = 6,
   parameter int  FN_W         = 6,
   parameter bit  SPLIT_DECODE = 1'b1
) (
   input  logic [OP_W-1:0]     op_i,
   input  logic [FN_W-1:0]     fn_i,
   output logic [NUM_INST-1:0] inst_o
);
   localparam int OP_LINES = 1 << OP_W;
   localparam int FN_LINES = 1 << FN_W;

   if (OP_W != 6 || FN_W != 6) begin : g_bad_width
      $error("insn_match: opcode and function fields must be 6 bits");
   end

   if (SPLIT_DECODE) begin : g_split
      logic [OP_LINES-1:0] op_hot;
      logic [FN_LINES-1:0] fn_hot;
      assign op_hot = {{(OP_LINES-1){1'b0}}, 1'b1} << op_i;
      assign fn_hot = {{(FN_LINES-1){1'b0}}, 1'b1} << fn_i;
      for (genvar i = 0; i < NUM_INST; i++) begin : g_line
         if (is_rfmt(i)) begin : g_r
            assign inst_o[i] = op_hot[op_code(i)] & fn_hot[fn_code(i)];
         end else begin : g_i
            assign inst_o[i] = op_hot[op_code(i)];
         end
      end
   end else begin : g_cmp
      for (genvar i = 0; i < NUM_INST; i++) begin : g_line
         if (is_rfmt(i)) begin : g_r
            assign inst_o[i] = (op_i == op_code(i)) && (fn_i == fn_code(i));
         end else begin : g_i
            assign inst_o[i] = (op_i == op_code(i));
         end
      end
   end

   always_comb begin
      if (!$isunknown({op_i, fn_i})) begin
         AST_ONE_IDENTITY: assert ($onehot0(inst_o)) else $error("two identity lines"); // R3
         AST_FN_ONLY_OP0: assert (op_i == '0 || inst_o[LAST_RFMT:0] == '0)
            else $error("R-format line with nonzero opcode"); // R2
      end
   end
endmodule

// File: rtl/insn_class.sv
module insn_class
   import insn_dec_pkg::*;
(
   input  logic [NUM_INST-1:0] inst_i,
   output logic                arith_o,
   output logic                logic_o,
   output logic                imm_o
);
   assign arith_o = inst_i[IX_ADD] | inst_i[IX_SUB] | inst_i[IX_SLT]
                  | inst_i[IX_ADDI] | inst_i[IX_SLTI];
   assign logic_o = inst_i[IX_AND] | inst_i[IX_OR] | inst_i[IX_XOR] | inst_i[IX_NOR]
                  | inst_i[IX_ANDI] | inst_i[IX_ORI] | inst_i[IX_XORI];
   assign imm_o   = inst_i[IX_LUI] | inst_i[IX_ADDI] | inst_i[IX_SLTI]
                  | inst_i[IX_ANDI] | inst_i[IX_ORI] | inst_i[IX_XORI];

   always_comb begin
      if (!$isunknown(inst_i)) begin
         AST_CLASS_DISJOINT: assert (!(arith_o && logic_o)) else $error("class overlap"); // R4
      end
   end
endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
   import insn_dec_pkg::*;
(
   input  logic [NUM_INST-1:0] inst_i,
   input  logic                arith_i,
   input  logic                logic_i,
   input  logic                imm_i,
   output logic                reg_wr_o,
   output logic                alu_imm_o,
   output logic                alu_sub_o,
   output logic                mem_rd_o,
   output logic                mem_wr_o,
   output logic [1:0]          pc_sel_o,
   output logic [1:0]          dst_sel_o,
   output logic                illegal_o
);
   logic rfmt_wr;

   assign rfmt_wr   = |inst_i[IX_NOR:IX_ADD];
   assign reg_wr_o  = inst_i[IX_LUI] | arith_i | logic_i | inst_i[IX_LW] | inst_i[IX_JAL];
   assign alu_imm_o = imm_i | inst_i[IX_LW] | inst_i[IX_SW];
   assign alu_sub_o = inst_i[IX_SUB] | inst_i[IX_SLT] | inst_i[IX_SLTI];
   assign mem_rd_o  = inst_i[IX_LW];
   assign mem_wr_o  = inst_i[IX_SW];
   assign pc_sel_o[0] = inst_i[IX_J] | inst_i[IX_JAL] | inst_i[IX_SYSCALL];
   assign pc_sel_o[1] = inst_i[IX_JR] | inst_i[IX_SYSCALL];
   assign illegal_o = ~|inst_i;

   always_comb begin
      if (inst_i[IX_JAL])      dst_sel_o = DST_LINK;
      else if (rfmt_wr)        dst_sel_o = DST_RD;
      else                     dst_sel_o = DST_RT;
   end

   always_comb begin
      if (!$isunknown(inst_i)) begin
         AST_ILLEGAL_QUIET: assert (!illegal_o || !(reg_wr_o || mem_wr_o || mem_rd_o || pc_sel_o != PC_SEQ))
            else $error("illegal word has side effects"); // R11
         AST_STORE_NO_REG: assert (!(mem_wr_o && reg_wr_o)) else $error("store writes register"); // R8
         AST_LOAD_IMM: assert (!mem_rd_o || alu_imm_o) else $error("load without immediate"); // R6
         AST_LINK_JUMPS: assert (dst_sel_o != DST_LINK || pc_sel_o == PC_JTA)
            else $error("link without jump"); // R10
         AST_SUB_ARITH: assert (!alu_sub_o || arith_i) else $error("subtract outside arithmetic"); // R7
      end
   end
endmodule

// File: rtl/insn_decode_ctrl.sv
module insn_decode_ctrl
   import insn_dec_pkg::*;
#(
   parameter int OP_W         = 6,
   parameter int FN_W         = 6,
   parameter bit SPLIT_DECODE = 1'b1
) (
   input  logic [OP_W-1:0]     op_i,
   input  logic [FN_W-1:0]     fn_i,
   output logic [NUM_INST-1:0] inst_o,
   output logic                arith_o,
   output logic                logic_o,
   output logic                imm_o,
   output logic                reg_wr_o,
   output logic                alu_imm_o,
   output logic                alu_sub_o,
   output logic                mem_rd_o,
   output logic                mem_wr_o,
   output logic [1:0]          pc_sel_o,
   output logic [1:0]          dst_sel_o,
   output logic                illegal_o
);
   insn_match #(.OP_W(OP_W), .FN_W(FN_W), .SPLIT_DECODE(SPLIT_DECODE)) u_match (
      .op_i   (op_i),
      .fn_i   (fn_i),
      .inst_o (inst_o)
   );

   insn_class u_class (
      .inst_i  (inst_o),
      .arith_o (arith_o),
      .logic_o (logic_o),
      .imm_o   (imm_o)
   );

   insn_ctrl u_ctrl (
      .inst_i    (inst_o),
      .arith_i   (arith_o),
      .logic_i   (logic_o),
      .imm_i     (imm_o),
      .reg_wr_o  (reg_wr_o),
      .alu_imm_o (alu_imm_o),
      .alu_sub_o (alu_sub_o),
      .mem_rd_o  (mem_rd_o),
      .mem_wr_o  (mem_wr_o),
      .pc_sel_o  (pc_sel_o),
      .dst_sel_o (dst_sel_o),
      .illegal_o (illegal_o)
   );

   always_comb begin
      if (!$isunknown({op_i, fn_i})) begin
         AST_LEGAL_XOR_ID: assert (illegal_o != (|inst_o)) else $error("illegal flag mismatch"); // R3
         AST_NO_WRITE_UNKNOWN: assert (|inst_o || !(reg_wr_o || mem_wr_o)) else $error("write on unknown"); // R11
      end
   end
endmodule

// File: tb/insn_decode_ctrl_test.sv
module insn_decode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 28;
   localparam logic [4:0] NONE = 5'd31;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [5:0] op = '0, fn = '0;
   logic [21:0] inst;
   logic arith, lgc, imm, reg_wr, alu_imm, alu_sub, mem_rd, mem_wr, illegal;
   logic [1:0] pc_sel, dst_sel;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_decode_ctrl uut (
      .op_i(op), .fn_i(fn), .inst_o(inst), .arith_o(arith), .logic_o(lgc), .imm_o(imm),
      .reg_wr_o(reg_wr), .alu_imm_o(alu_imm), .alu_sub_o(alu_sub), .mem_rd_o(mem_rd),
      .mem_wr_o(mem_wr), .pc_sel_o(pc_sel), .dst_sel_o(dst_sel), .illegal_o(illegal)
   );

   // {opcode, function, expected identity index (31 = none)}
   localparam logic [16:0] VEC [0:NV-1] = '{
      {6'd0, 6'd32, 5'd0},  {6'd0, 6'd34, 5'd1},  {6'd0, 6'd42, 5'd2},  {6'd0, 6'd36, 5'd3},
      {6'd0, 6'd37, 5'd4},  {6'd0, 6'd38, 5'd5},  {6'd0, 6'd39, 5'd6},  {6'd0, 6'd8, 5'd7},
      {6'd0, 6'd12, 5'd8},  {6'd15, 6'd0, 5'd9},  {6'd8, 6'd3, 5'd10},  {6'd10, 6'd7, 5'd11},
      {6'd12, 6'd1, 5'd12}, {6'd13, 6'd63, 5'd13}, {6'd14, 6'd5, 5'd14}, {6'd35, 6'd32, 5'd15},
      {6'd43, 6'd34, 5'd16}, {6'd2, 6'd8, 5'd17}, {6'd3, 6'd12, 5'd18}, {6'd1, 6'd0, 5'd19},
      {6'd4, 6'd42, 5'd20}, {6'd5, 6'd9, 5'd21},
      {6'd0, 6'd0, NONE},   {6'd0, 6'd33, NONE},  {6'd0, 6'd35, NONE},  {6'd6, 6'd32, NONE},
      {6'd63, 6'd8, NONE},  {6'd9, 6'd12, NONE}
   };

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s op=%0d fn=%0d actual=%0h expected=%0h", req, what, op, fn, act, exp);
      end
   endtask

   function automatic bit in_set(input int x, input int s[$]);
      foreach (s[k]) if (s[k] == x) return 1'b1;
      return 1'b0;
   endfunction

   task automatic apply(input logic [5:0] o, input logic [5:0] f);
      @(negedge clk);
      op = o; fn = f;
      #(CLK_PERIOD/4);
   endtask

   task automatic check_idx(input int ix);
      bit a, l, im, rw;
      int pcs, dst;
      a  = in_set(ix, '{0, 1, 2, 10, 11});
      l  = in_set(ix, '{3, 4, 5, 6, 12, 13, 14});
      im = in_set(ix, '{9, 10, 11, 12, 13, 14});
      rw = a | l | in_set(ix, '{9, 15, 18});
      pcs = (in_set(ix, '{17, 18, 8}) ? 1 : 0) + (in_set(ix, '{7, 8}) ? 2 : 0);
      dst = (ix == 18) ? 2 : (ix <= 6 ? 1 : 0);
      chk(ix <= 8 ? "R1" : "R2", inst, (ix == NONE) ? 0 : (1 << ix), "identity");
      chk("R3", illegal, ix == NONE, "illegal");
      chk("R4", {arith, lgc, imm}, {a, l, im}, "classes");
      chk(ix == NONE ? "R11" : "R5", reg_wr, rw, "reg_wr");
      chk("R6", alu_imm, im | (ix == 15) | (ix == 16), "alu_imm");
      chk("R7", alu_sub, in_set(ix, '{1, 2, 11}), "alu_sub");
      chk("R8", {mem_rd, mem_wr}, {ix == 15, ix == 16}, "mem");
      chk(ix == NONE ? "R11" : "R9", pc_sel, pcs, "pc_sel");
      chk("R10", dst_sel, dst, "dst_sel");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n_ill, n_rw, n_sw;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle word (all zero) after reset: not a supported instruction, R3 and R11
      apply(6'd0, 6'd0);
      check_idx(NONE);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][16:11], VEC[v][10:5]);
         check_idx(int'(VEC[v][4:0]));
      end

      // function field ignored outside opcode 0: R2
      apply(6'd35, 6'd8);  check_idx(15);
      apply(6'd8, 6'd34);  check_idx(10);

      // exhaustive sweep: 9 R-format + 13*64 I-format encodings legal, R3 R5 R8
      n_ill = 0; n_rw = 0; n_sw = 0;
      for (int o = 0; o < 64; o++) begin
         for (int f = 0; f < 64; f++) begin
            op = 6'(o); fn = 6'(f);
            #1;
            n_ill += int'(illegal);
            n_rw  += int'(reg_wr);
            n_sw  += int'(mem_wr);
         end
      end
      chk("R3", n_ill, 4096 - 841, "illegal count");
      chk("R5", n_rw, 7 + 8 * 64, "reg_wr count");
      chk("R8", n_sw, 64, "mem_wr count");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule